// File: doc/BRIEF.md
# Speculative Read-Bit Violation Detector

This block sits beside the L1 data cache tag array of one processor in a four-processor chip multiprocessor that runs speculative threads. It keeps a small state record for each cache line: valid, tag, a read bit, a dirty bit and a pre-invalidate bit. Local loads and stores update the read and dirty bits while the local thread is speculative. Stores that other processors broadcast on the shared write bus are classified by the writer's thread order relative to the local thread. A store from an earlier thread invalidates the matching local line and checks it for a read-after-write hazard. A store from a later thread only marks the line for invalidation at the local processor's next thread start.

Thread order comes from a ring of processor ids. The current head (the non-speculative thread) has position 0, and each other processor has position `(id - head) mod NCPU`. A hazard raises a sticky violation flag that the control side clears with an acknowledge. The control side also issues commit, squash and thread-start commands that clean up the speculative state.

Top module: `rbv_detect`

## Requirements
- R1: After reset every line is invalid, all read, dirty and pre-invalidate bits are 0, and `viol_o`, `inv_o` and `preinv_o` are 0.
- R2: A load sets its line valid with the load's tag, whether it hits or refills on a miss. The read bit is set only when the local thread is speculative (`cpu_id_i != head_i`). Address bits [IDX_W-1:0] select the line and the upper bits form the tag. All state outputs show the result one cycle after the event.
- R3: A store that hits while the thread is speculative sets the line's dirty bit. A store that misses changes no line.
- R4: A bus store from an earlier thread that hits a valid line with a matching tag clears that line's valid bit. It also pulses `inv_o` for one cycle, with `act_idx_o` set to the line index, one cycle after the store.
- R5: If that earlier-thread store hits a line whose read bit is set, `viol_o` goes to 1 one cycle after the store.
- R6: A bus store from a later thread that hits sets the line's pre-invalidate bit and pulses `preinv_o`. The line stays valid and `viol_o` does not change.
- R7: A bus store whose source id equals `cpu_id_i` has no effect on any line or output.
- R8: The writer is earlier exactly when `(src - head) mod NCPU < (cpu_id - head) mod NCPU`.
- R9: `viol_o` stays at 1 until a cycle with `viol_ack_i` set and no new hazard. A hazard in the same cycle as an acknowledge leaves `viol_o` at 1.
- R10: `commit_i` clears all read and dirty bits and leaves valid bits unchanged.
- R11: `squash_i` clears all read and dirty bits and invalidates every line that was dirty.
- R12: `start_i` invalidates every pre-invalidated line and clears all pre-invalidate bits.
- R13: In a cycle with `commit_i`, `squash_i` or `start_i` set, loads, stores and bus stores are ignored.
- R14: A bus store whose tag does not match the line's tag, or that hits an invalid line, causes no action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_id_i | input | CPU_W | Id of the local processor |
| head_i | input | CPU_W | Id of the processor running the head thread |
| ld_v_i | input | 1 | Local load event |
| ld_addr_i | input | ADDR_W | Load line address |
| st_v_i | input | 1 | Local store event |
| st_addr_i | input | ADDR_W | Store line address |
| bw_v_i | input | 1 | Bus store seen on the write bus |
| bw_src_i | input | CPU_W | Processor id of the bus writer |
| bw_addr_i | input | ADDR_W | Bus store line address |
| commit_i | input | 1 | Commit the local thread |
| squash_i | input | 1 | Squash the local thread |
| start_i | input | 1 | Local processor begins its next thread |
| viol_ack_i | input | 1 | Acknowledge the violation flag |
| viol_o | output | 1 | Sticky read-after-write violation flag |
| inv_o | output | 1 | One-cycle invalidate action pulse |
| preinv_o | output | 1 | One-cycle pre-invalidate action pulse |
| act_idx_o | output | IDX_W | Line index of the last action |
| valid_o | output | LINES | Valid bit of every line |
| read_o | output | LINES | Read bit of every line |
| dirty_o | output | LINES | Dirty bit of every line |
| pre_o | output | LINES | Pre-invalidate bit of every line |

## Verification
Every line bit is a register that drives an output directly, so a wrong line state appears on `valid_o`, `read_o`, `dirty_o` or `pre_o` one clock after the event that caused it. A wrong ring-order decision shows up in the same cycle as a swapped `inv_o`/`preinv_o` pulse and a wrong `viol_o`. A read bit that was lost or set in error only shows later, as a missing or false violation at the next earlier-thread store to that line. The sweep therefore covers every combination of local id, head and writer, with the expected order computed arithmetically.

// File: rtl/rbv_pkg.sv
package rbv_pkg;
  typedef struct packed {
    logic valid;
    logic rd;
    logic dty;
    logic pre;
  } line_st_t;
endpackage

// File: rtl/rbv_order.sv
module rbv_order #(
  parameter int NCPU  = 4,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic [CPU_W-1:0] self_i,
  input  logic [CPU_W-1:0] head_i,
  input  logic [CPU_W-1:0] src_i,
  output logic             earlier_o,
  output logic             same_o,
  output logic             spec_o
);
  localparam int PW = CPU_W + 1;

  function automatic logic [PW-1:0] ring_pos(input logic [CPU_W-1:0] id,
                                             input logic [CPU_W-1:0] hd);
    logic [PW-1:0] a, h;
    a = {1'b0, id};
    h = {1'b0, hd};
    return (a >= h) ? (a - h) : (a + PW'(NCPU) - h);
  endfunction

  logic [PW-1:0] pos_self, pos_src;

  always_comb begin
    pos_self  = ring_pos(self_i, head_i);
    pos_src   = ring_pos(src_i, head_i);
    same_o    = (src_i == self_i);
    earlier_o = !same_o && (pos_src < pos_self);
    spec_o    = (self_i != head_i);
  end
endmodule

// File: rtl/rbv_line.sv
module rbv_line
  import rbv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spec_i,
  input  logic             ld_sel_i,
  input  logic [TAG_W-1:0] ld_tag_i,
  input  logic             st_sel_i,
  input  logic [TAG_W-1:0] st_tag_i,
  input  logic             bw_sel_i,
  input  logic [TAG_W-1:0] bw_tag_i,
  input  logic             bw_earlier_i,
  input  logic             commit_i,
  input  logic             squash_i,
  input  logic             start_i,
  output line_st_t         st_o,
  output logic             bw_inv_o,
  output logic             bw_pre_o,
  output logic             bw_raw_o
);
  line_st_t         st_q, st_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             ctl, bw_hit, ld_hit, st_hit;

  always_comb begin
    ctl      = commit_i | squash_i | start_i;
    bw_hit   = bw_sel_i && st_q.valid && (tag_q == bw_tag_i);
    ld_hit   = st_q.valid && (tag_q == ld_tag_i);
    st_hit   = st_q.valid && (tag_q == st_tag_i);
    bw_inv_o = bw_hit && bw_earlier_i;
    bw_pre_o = bw_hit && !bw_earlier_i;
    bw_raw_o = bw_inv_o && st_q.rd;
  end

  always_comb begin
    st_d  = st_q;
    tag_d = tag_q;
    if (ctl) begin
      if (commit_i || squash_i) begin
        st_d.rd  = 1'b0;
        st_d.dty = 1'b0;
        if (squash_i && st_q.dty) st_d.valid = 1'b0;
      end
      if (start_i) begin
        if (st_q.pre) st_d.valid = 1'b0;
        st_d.pre = 1'b0;
      end
    end else if (bw_inv_o) begin
      st_d = '0;
    end else begin
      if (bw_pre_o) st_d.pre = 1'b1;
      if (ld_sel_i) begin
        if (ld_hit) begin
          st_d.rd = st_q.rd | spec_i;
        end else begin
          st_d  = '{valid: 1'b1, rd: spec_i, dty: 1'b0, pre: 1'b0};
          tag_d = ld_tag_i;
        end
      end
      if (st_sel_i && st_hit && spec_i) st_d.dty = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      tag_q <= tag_d;
    end
  end

  assign st_o = st_q;

  a_r10_commit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i || squash_i) |=> (!st_q.rd && !st_q.dty));
  a_r11_squash_drops_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_i && st_q.dty) |=> !st_q.valid);
  a_r12_start_drops_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q.pre) |=> (!st_q.valid && !st_q.pre));
  a_r4_earlier_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_inv_o && !ctl) |=> !st_q.valid);
  a_r6_later_keeps_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_pre_o && !ctl && !ld_sel_i) |=> (st_q.valid && st_q.pre));
endmodule

// File: rtl/rbv_flag.sv
module rbv_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (ack_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q);
  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !flag_q);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/rbv_detect.sv
module rbv_detect
  import rbv_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int LINES = 8,
  parameter int TAG_W = 4,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_W-1:0]  cpu_id_i,
  input  logic [CPU_W-1:0]  head_i,
  input  logic              ld_v_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              st_v_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              bw_v_i,
  input  logic [CPU_W-1:0]  bw_src_i,
  input  logic [ADDR_W-1:0] bw_addr_i,
  input  logic              commit_i,
  input  logic              squash_i,
  input  logic              start_i,
  input  logic              viol_ack_i,
  output logic              viol_o,
  output logic              inv_o,
  output logic              preinv_o,
  output logic [IDX_W-1:0]  act_idx_o,
  output logic [LINES-1:0]  valid_o,
  output logic [LINES-1:0]  read_o,
  output logic [LINES-1:0]  dirty_o,
  output logic [LINES-1:0]  pre_o
);
  logic earlier, same, spec, ctl, bw_act;
  logic [LINES-1:0] l_inv, l_pre, l_raw;
  logic any_inv, any_pre, any_raw;
  logic [IDX_W-1:0] ld_idx, st_idx, bw_idx;

  assign ld_idx = ld_addr_i[IDX_W-1:0];
  assign st_idx = st_addr_i[IDX_W-1:0];
  assign bw_idx = bw_addr_i[IDX_W-1:0];
  assign ctl    = commit_i | squash_i | start_i;

  rbv_order #(.NCPU(NCPU)) u_order (
    .self_i    (cpu_id_i),
    .head_i    (head_i),
    .src_i     (bw_src_i),
    .earlier_o (earlier),
    .same_o    (same),
    .spec_o    (spec)
  );

  assign bw_act = bw_v_i && !same;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t st;
    rbv_line #(.TAG_W(TAG_W)) u_line (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .spec_i       (spec),
      .ld_sel_i     (ld_v_i && (ld_idx == IDX_W'(g))),
      .ld_tag_i     (ld_addr_i[ADDR_W-1:IDX_W]),
      .st_sel_i     (st_v_i && (st_idx == IDX_W'(g))),
      .st_tag_i     (st_addr_i[ADDR_W-1:IDX_W]),
      .bw_sel_i     (bw_act && (bw_idx == IDX_W'(g))),
      .bw_tag_i     (bw_addr_i[ADDR_W-1:IDX_W]),
      .bw_earlier_i (earlier),
      .commit_i     (commit_i),
      .squash_i     (squash_i),
      .start_i      (start_i),
      .st_o         (st),
      .bw_inv_o     (l_inv[g]),
      .bw_pre_o     (l_pre[g]),
      .bw_raw_o     (l_raw[g])
    );
    assign valid_o[g] = st.valid;
    assign read_o[g]  = st.rd;
    assign dirty_o[g] = st.dty;
    assign pre_o[g]   = st.pre;
  end

  assign any_inv = |l_inv && !ctl;
  assign any_pre = |l_pre && !ctl;
  assign any_raw = |l_raw && !ctl;

  rbv_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (any_raw),
    .ack_i  (viol_ack_i),
    .flag_o (viol_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_o     <= 1'b0;
      preinv_o  <= 1'b0;
      act_idx_o <= '0;
    end else begin
      inv_o    <= any_inv;
      preinv_o <= any_pre;
      if (any_inv || any_pre) act_idx_o <= bw_idx;
    end
  end

  a_r6_later_no_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_v_i && !earlier && !viol_o) |=> !viol_o);
  a_r7_own_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_v_i && same) |=> (!inv_o && !preinv_o));
  a_r13_ctl_blocks_actions: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl |=> (!inv_o && !preinv_o));
  a_r4_action_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inv_o && preinv_o));
endmodule

// File: tb/sim_rbv_detect.sv
module sim_rbv_detect;
  localparam int NCPU = 4, LINES = 8, TAG_W = 4;
  localparam int CPU_W = 2, IDX_W = 3, ADDR_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CPU_W-1:0] cpu_id = '0, head = '0, bw_src = '0;
  logic ld_v = 0, st_v = 0, bw_v = 0, commit = 0, squash = 0, start = 0, ack = 0;
  logic [ADDR_W-1:0] ld_addr = '0, st_addr = '0, bw_addr = '0;
  logic viol, inv, preinv;
  logic [IDX_W-1:0] act_idx;
  logic [LINES-1:0] valid, rd, dty, pre;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rbv_detect #(.NCPU(NCPU), .LINES(LINES), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_id_i(cpu_id), .head_i(head),
    .ld_v_i(ld_v), .ld_addr_i(ld_addr), .st_v_i(st_v), .st_addr_i(st_addr),
    .bw_v_i(bw_v), .bw_src_i(bw_src), .bw_addr_i(bw_addr),
    .commit_i(commit), .squash_i(squash), .start_i(start), .viol_ack_i(ack),
    .viol_o(viol), .inv_o(inv), .preinv_o(preinv), .act_idx_o(act_idx),
    .valid_o(valid), .read_o(rd), .dirty_o(dty), .pre_o(pre));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ld_v = 0; st_v = 0; bw_v = 0; commit = 0; squash = 0; start = 0; ack = 0;
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return ADDR_W'(tag * LINES + idx);
  endfunction

  function automatic int pos(input int id, input int hd);
    return (id + NCPU - hd) % NCPU;
  endfunction

  task automatic clean();
    squash = 1; start = 1; ack = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(valid), 0);
    chk("R1 flags", {29'd0, viol, inv, preinv}, 0);
    chk("R1 bits", 32'({rd, dty, pre}), 0);

    // R8 sweep over self, head, writer (R4 R5 R6 R7 R2)
    for (int s = 0; s < NCPU; s++)
      for (int h = 0; h < NCPU; h++)
        for (int w = 0; w < NCPU; w++) begin
          bit sp, er, lt;
          cpu_id = CPU_W'(s); head = CPU_W'(h);
          clean();
          sp = (s != h);
          er = (w != s) && (pos(w, h) < pos(s, h));
          lt = (w != s) && !er;
          ld_v = 1; ld_addr = mk(5, 3); tick();
          chk("R2 read bit", 32'(rd[3]), 32'(sp));
          chk("R2 valid", 32'(valid[3]), 1);
          bw_v = 1; bw_src = CPU_W'(w); bw_addr = mk(5, 3); tick();
          chk("R8 R4 valid", 32'(valid[3]), 32'(!er));
          chk("R8 R4 inv", 32'(inv), 32'(er));
          chk("R8 R5 viol", 32'(viol), 32'(er && sp));
          chk("R8 R6 pre", 32'(pre[3]), 32'(lt));
          chk("R6 preinv", 32'(preinv), 32'(lt));
          if (er || lt) chk("R4 act_idx", 32'(act_idx), 3);
          if (w == s) chk("R7 own write", {30'd0, inv, preinv}, 0);
        end

    cpu_id = 2; head = 0; // writer 1 earlier, writer 3 later
    clean(); tick(); tick();
    // R3 store hit/miss
    ld_v = 1; ld_addr = mk(2, 2); tick();
    st_v = 1; st_addr = mk(2, 2); tick();
    chk("R3 dirty hit", 32'(dty[2]), 1);
    st_v = 1; st_addr = mk(3, 4); tick();
    chk("R3 miss no line", 32'({valid[4], dty[4]}), 0);
    // R10 commit
    commit = 1; tick();
    chk("R10 bits cleared", 32'({rd[2], dty[2]}), 0);
    chk("R10 valid kept", 32'(valid[2]), 1);
    // R11 squash
    ld_v = 1; ld_addr = mk(2, 2); tick();
    st_v = 1; st_addr = mk(2, 2); tick();
    ld_v = 1; ld_addr = mk(1, 5); tick();
    squash = 1; tick();
    chk("R11 dirty line dropped", 32'(valid[2]), 0);
    chk("R11 clean line kept", 32'(valid[5]), 1);
    chk("R11 read cleared", 32'(rd), 0);
    // R14 tag mismatch
    ld_v = 1; ld_addr = mk(1, 6); tick();
    bw_v = 1; bw_src = 1; bw_addr = mk(2, 6); tick();
    chk("R14 valid kept", 32'(valid[6]), 1);
    chk("R14 no action", {30'd0, viol, inv}, 0);
    // R9 sticky, ack, set-wins
    bw_v = 1; bw_src = 1; bw_addr = mk(1, 6); tick();
    chk("R9 raised", 32'(viol), 1);
    tick(); tick();
    chk("R9 held", 32'(viol), 1);
    ack = 1; tick();
    chk("R9 ack clears", 32'(viol), 0);
    ld_v = 1; ld_addr = mk(4, 1); tick();
    bw_v = 1; bw_src = 1; bw_addr = mk(4, 1); ack = 1; tick();
    chk("R9 set beats ack", 32'(viol), 1);
    ack = 1; tick();
    // R13 control precedence
    ld_v = 1; ld_addr = mk(3, 7); tick();
    bw_v = 1; bw_src = 1; bw_addr = mk(3, 7); commit = 1; tick();
    chk("R13 line kept", 32'(valid[7]), 1);
    chk("R13 no action", {30'd0, viol, inv}, 0);
    ld_v = 1; ld_addr = mk(6, 0); start = 1; tick();
    chk("R13 load ignored", 32'(valid[0]), 0);
    // R12 start
    ld_v = 1; ld_addr = mk(3, 7); tick();
    bw_v = 1; bw_src = 3; bw_addr = mk(3, 7); tick();
    chk("R12 pre set", 32'({valid[7], pre[7]}), 3);
    start = 1; tick();
    chk("R12 start drops pre line", 32'({valid[7], pre[7]}), 0);
    // R2 head thread load sets no read bit
    head = 2; ld_v = 1; ld_addr = mk(2, 4); tick();
    chk("R2 head no read", 32'({valid[4], rd[4]}), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule